// File: doc/BRIEF.md
# Bridge Address Retry Generator

This block sits in a host bridge, on the side facing the processor bus. It decides when the bridge itself must retry an address tenure that a processor has started. It watches four hazards that belong to the bridge:

- a cast-out is pending in the bridge's own second-level cache controller;
- the tenure's cache line matches a line held in one of the bridge's internal buffers;
- a processor reads an I/O-bus target while another master holds the I/O bus in a transaction that needs a snoop;
- a processor writes to the I/O bus while the processor-to-I/O write buffer is full and an I/O master waits on a memory access that needs a snoop. Retrying here breaks the deadlock.

Any one of these raises a single registered retry output. That output is only driven in the legal window of the tenure, which opens in the cycle after transfer-start and closes with the cycle after address-acknowledge.

The bridge drives transfer-start, address-acknowledge and the tenure attributes from its bus tracker. The buffers, the cache controller and the I/O bus sequencer provide the hazard flags and the buffer addresses. A four-bit cause vector records which hazards fired during the current tenure's window, for debug. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `addr_retry_gen`

## Requirements
- R1: After reset, `retry` is 0 and `retry_cause` is 0.
- R2: While no tenure window is open, `retry` stays 0 whatever the hazard inputs are, and `retry_cause` keeps its value.
- R3: A pending cast-out (`l2_castout` = 1) seen in the transfer-start cycle or in an open, non-final window cycle raises `retry` in the next cycle.
- R4: A tenure whose address equals the address of a valid buffer entry in every bit above the low LINE_BITS bits (5 by default) raises `retry`. The low bits are ignored, and a different line does not raise it.
- R5: A buffer entry with its valid bit at 0 never matches, even when its line equals the tenure line.
- R6: A read (`tn_write` = 0) to an I/O target (`tn_io` = 1) while `io_busy_snoop` = 1 raises `retry`. A write, or a read to memory (`tn_io` = 0), does not raise it on this hazard.
- R7: A write to an I/O target raises `retry` only when both `io_wbuf_full` and `io_mem_snoop` are 1. Either one alone does not raise it.
- R8: A hazard present in the transfer-start cycle makes `retry` 1 in the very next cycle, which is the first cycle of the window.
- R9: Once raised, `retry` stays 1 through the cycle after the `aack` cycle, and it is 0 in the cycle after that.
- R10: A hazard that first appears in a mid-window cycle raises `retry` in the following cycle. A hazard that first appears only in the final window cycle (the cycle after `aack`) does not raise `retry`.
- R11: `retry_cause` bit 0 is the cast-out hazard, bit 1 the buffer collision, bit 2 the busy-bus read and bit 3 the full-buffer write. The vector is cleared at transfer-start, gathers every hazard seen up to the last cycle that can still raise `retry`, and then holds until the next transfer-start.
- R12: The tenure address, direction and target are taken in the transfer-start cycle. Later changes on `tn_addr` during the tenure have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts | input | 1 | Transfer-start, one cycle per tenure |
| aack | input | 1 | Address-acknowledge; only counts while the window is open |
| tn_addr | input | AW | Tenure address |
| tn_write | input | 1 | 1 for a write tenure, 0 for a read |
| tn_io | input | 1 | 1 when the tenure targets the I/O bus |
| l2_castout | input | 1 | Cast-out pending in the internal cache controller |
| buf_line_addr | input | NBUF*AW | Addresses held in the internal buffers, entry i at bits i*AW upward |
| buf_valid | input | NBUF | Valid bit per buffer entry |
| io_wbuf_full | input | 1 | Processor-to-I/O write buffer full |
| io_busy_snoop | input | 1 | I/O bus held by another master in a transaction needing a snoop |
| io_mem_snoop | input | 1 | An I/O master waits on a memory access that needs a snoop |
| retry | output | 1 | Registered address-retry request |
| retry_cause | output | 4 | Hazards seen during the current tenure (bit map in R11) |

## Verification
Two things can land in the same cycle: a hazard is detected, and the window reaches its final cycle. The bench provokes this by pulsing the cast-out flag once per tenure and sliding the pulse across the window. A pulse in the `aack` cycle must still produce one cycle of `retry`. A pulse one cycle later must produce nothing and must leave the cause vector at zero. A second overlap is a hazard that is already present in the transfer-start cycle itself: the bench judges it by checking that `retry` is high in the first window cycle, before the latched tenure attributes are in use.

// File: rtl/arty_pkg.sv
package arty_pkg;
  localparam int CAUSE_W = 4;

  // Bit order is visible on retry_cause: bit0 cast-out, bit1 collision,
  // bit2 busy-bus read, bit3 full-buffer write.
  typedef struct packed {
    logic wr_full;
    logic rd_busy;
    logic collide;
    logic castout;
  } cause_t;
endpackage

// File: rtl/arty_line_cmp.sv
module arty_line_cmp #(
  parameter int AW        = 32,
  parameter int LINE_BITS = 5,
  parameter int NBUF      = 4
) (
  input  logic [AW-1:0]      addr,
  input  logic [NBUF*AW-1:0] buf_addr,
  input  logic [NBUF-1:0]    buf_vld,
  output logic [NBUF-1:0]    match,
  output logic               hit
);
  // Mask that keeps only the line part of an address.
  localparam logic [AW-1:0] LMASK = ~((AW'(1) << LINE_BITS) - AW'(1));

  logic [AW-1:0] line_q;
  assign line_q = addr & LMASK;

  for (genvar g = 0; g < NBUF; g++) begin : g_ent
    logic [AW-1:0] ent_line;
    assign ent_line = buf_addr[g*AW +: AW] & LMASK;
    assign match[g] = buf_vld[g] && (ent_line == line_q);
  end

  assign hit = |match;
endmodule

// File: rtl/arty_cond_dec.sv
module arty_cond_dec
  import arty_pkg::*;
(
  input  logic   castout_pend,
  input  logic   line_hit,
  input  logic   is_write,
  input  logic   is_io,
  input  logic   io_busy_snoop,
  input  logic   wbuf_full,
  input  logic   io_mem_snoop,
  output cause_t cause
);
  always_comb begin
    cause         = '0;
    cause.castout = castout_pend;
    cause.collide = line_hit;
    // A processor read to I/O cannot finish while a snooping master holds the bus.
    cause.rd_busy = !is_write && is_io && io_busy_snoop;
    // A posted write that cannot drain, while an I/O master waits on a snoop.
    cause.wr_full = is_write && is_io && wbuf_full && io_mem_snoop;
  end
endmodule

// File: rtl/arty_window.sv
module arty_window (
  input  logic clk,
  input  logic rst_n,
  input  logic ts,
  input  logic aack,
  output logic win,       // current cycle lies inside the retry window
  output logic last,      // current cycle is the one after aack (final window cycle)
  output logic win_next   // next cycle lies inside the window
);
  logic win_q, last_q;
  logic open_mid;

  assign open_mid = win_q && !last_q;
  assign win_next = ts || open_mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      win_q  <= win_next;
      last_q <= open_mid && aack && !ts;
    end
  end

  assign win  = win_q;
  assign last = last_q;

  p_last_inside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> win_q);
  p_ts_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ts |=> (win_q && !last_q));
  p_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_q && !ts) |=> !win_q);
endmodule

// File: rtl/addr_retry_gen.sv
module addr_retry_gen
  import arty_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_BITS = 5,
  parameter int NBUF      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ts,
  input  logic               aack,
  input  logic [AW-1:0]      tn_addr,
  input  logic               tn_write,
  input  logic               tn_io,
  input  logic               l2_castout,
  input  logic [NBUF*AW-1:0] buf_line_addr,
  input  logic [NBUF-1:0]    buf_valid,
  input  logic               io_wbuf_full,
  input  logic               io_busy_snoop,
  input  logic               io_mem_snoop,
  output logic               retry,
  output logic [CAUSE_W-1:0] retry_cause
);
  // Tenure attributes captured at transfer-start.
  logic [AW-1:0] addr_q;
  logic          wr_q, io_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      io_q   <= 1'b0;
    end else if (ts) begin
      addr_q <= tn_addr;
      wr_q   <= tn_write;
      io_q   <= tn_io;
    end
  end

  // In the start cycle the live bus values are used, so that retry can be raised
  // in the first window cycle; afterwards the captured copy is used.
  logic [AW-1:0] cur_addr;
  logic          cur_wr, cur_io;
  assign cur_addr = ts ? tn_addr  : addr_q;
  assign cur_wr   = ts ? tn_write : wr_q;
  assign cur_io   = ts ? tn_io    : io_q;

  logic win, last, win_next;
  arty_window u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .ts       (ts),
    .aack     (aack),
    .win      (win),
    .last     (last),
    .win_next (win_next)
  );

  logic [NBUF-1:0] ent_match;
  logic            line_hit;
  arty_line_cmp #(.AW(AW), .LINE_BITS(LINE_BITS), .NBUF(NBUF)) u_cmp (
    .addr     (cur_addr),
    .buf_addr (buf_line_addr),
    .buf_vld  (buf_valid),
    .match    (ent_match),
    .hit      (line_hit)
  );

  cause_t now_cause;
  arty_cond_dec u_dec (
    .castout_pend  (l2_castout),
    .line_hit      (line_hit),
    .is_write      (cur_wr),
    .is_io         (cur_io),
    .io_busy_snoop (io_busy_snoop),
    .wbuf_full     (io_wbuf_full),
    .io_mem_snoop  (io_mem_snoop),
    .cause         (now_cause)
  );

  logic   retry_q;
  cause_t cause_q;
  logic   any_now;
  logic   hold;

  assign any_now = |now_cause;
  assign hold    = retry_q && !ts;   // a new tenure never inherits the old retry

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retry_q <= 1'b0;
      cause_q <= '0;
    end else begin
      retry_q <= win_next && (hold || any_now);
      if (ts)
        cause_q <= now_cause;
      else if (win_next)
        cause_q <= cause_q | now_cause;
    end
  end

  assign retry       = retry_q;
  assign retry_cause = cause_q;

  p_quiet_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> !retry_q);
  p_castout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_next && l2_castout) |=> retry_q);
  p_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_match & ~buf_valid) == '0);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_q && !last && !ts) |=> retry_q);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !ts) |=> !retry_q);
  p_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |-> (cause_q != '0));
  p_cause_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_next && !ts) |=> $stable(cause_q));
endmodule

// File: tb/tb_addr_retry_gen.sv
module tb_addr_retry_gen;
  localparam int AW = 32;
  localparam int NBUF = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic               rst_n, ts, aack, tn_write, tn_io, l2_castout;
  logic [AW-1:0]      tn_addr;
  logic [NBUF*AW-1:0] buf_line_addr;
  logic [NBUF-1:0]    buf_valid;
  logic               io_wbuf_full, io_busy_snoop, io_mem_snoop;
  logic               retry;
  logic [3:0]         retry_cause;

  addr_retry_gen dut (
    .clk(clk), .rst_n(rst_n), .ts(ts), .aack(aack), .tn_addr(tn_addr),
    .tn_write(tn_write), .tn_io(tn_io), .l2_castout(l2_castout),
    .buf_line_addr(buf_line_addr), .buf_valid(buf_valid),
    .io_wbuf_full(io_wbuf_full), .io_busy_snoop(io_busy_snoop),
    .io_mem_snoop(io_mem_snoop), .retry(retry), .retry_cause(retry_cause)
  );

  typedef struct {
    int         cyc;
    logic       a;
    logic [3:0] c;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares outputs against the scoreboard, away from the clock edge.
  always @(negedge clk) begin
    exp_t e;
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      e = exp_q.pop_front();
      checks++;
      if (e.cyc != cyc || retry !== e.a || retry_cause !== e.c) begin
        errors++;
        $display("FAIL %s cyc %0d: retry=%b cause=%b expected retry=%b cause=%b",
                 e.tag, cyc, retry, retry_cause, e.a, e.c);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Expected output for the cycle dt after the one now being driven.
  task automatic push(input int dt, input logic a, input logic [3:0] c, input string tag);
    exp_t e;
    e.cyc = cyc + dt; e.a = a; e.c = c; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // One tenure with static hazards: ts, then aack d cycles later.
  task automatic run(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                     input logic wr, input logic io, input int d,
                     input logic ea, input logic [3:0] ec, input string tag);
    step; ts = 1'b1; tn_addr = a0; tn_write = wr; tn_io = io; aack = 1'b0;
    push(1, ea, ec, tag);                                  // R8 first window cycle
    for (int i = 1; i <= d; i++) begin
      step; ts = 1'b0; tn_addr = a1; aack = (i == d);
      push(1, ea, ec, tag);                                // R9 held through window
    end
    step; aack = 1'b0;
    push(1, 1'b0, ec, {tag, "/R9 release"});
    step;
    push(1, 1'b0, ec, {tag, "/R11 hold"});
  endtask

  // One-cycle cast-out pulse at window offset rise (R10).
  task automatic run_pulse(input int d, input int rise, input string tag);
    logic [3:0] c;
    c = 4'b0000;
    for (int k = 0; k <= d + 1; k++) begin
      step; ts = (k == 0); aack = (k == d); l2_castout = (k == rise);
      tn_addr = 32'h0000_8000; tn_write = 1'b0; tn_io = 1'b0;
      if (k >= rise && rise <= d) c = 4'b0001;
      push(1, (k >= rise && k <= d), c, tag);
    end
    step; l2_castout = 1'b0; aack = 1'b0;
    push(1, 1'b0, c, {tag, "/end"});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ts = 1'b0; aack = 1'b0; tn_addr = '0; tn_write = 1'b0; tn_io = 1'b0;
    l2_castout = 1'b0; buf_line_addr = '0; buf_valid = '0;
    io_wbuf_full = 1'b0; io_busy_snoop = 1'b0; io_mem_snoop = 1'b0;
    repeat (3) step;
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (retry !== 1'b0 || retry_cause !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset: retry=%b cause=%b expected 0 0000", retry, retry_cause);
    end

    // R2: hazards with no tenure
    step; l2_castout = 1'b1; io_busy_snoop = 1'b1; tn_io = 1'b1;
    for (int i = 0; i < 3; i++) begin step; push(1, 1'b0, 4'b0000, "R2 idle"); end
    io_busy_snoop = 1'b0;

    // R3, R8, R9: cast-out pending, both ack distances
    run(32'h100, 32'h100, 1'b0, 1'b0, 1, 1'b1, 4'b0001, "R3 castout d1");
    run(32'h100, 32'h100, 1'b0, 1'b0, 3, 1'b1, 4'b0001, "R3 castout d3");
    // R2 after a tenure: cause held, retry low
    for (int i = 0; i < 2; i++) begin step; push(1, 1'b0, 4'b0001, "R2 idle held"); end
    step; l2_castout = 1'b0;

    // R4 collision on line-aligned compare
    buf_line_addr[0*AW +: AW] = 32'h0000_1000;
    buf_line_addr[2*AW +: AW] = 32'h0000_4000;
    buf_valid = 4'b0001;
    run(32'h0000_101C, 32'h0000_101C, 1'b0, 1'b0, 2, 1'b1, 4'b0010, "R4 same line");
    run(32'h0000_1020, 32'h0000_1020, 1'b0, 1'b0, 2, 1'b0, 4'b0000, "R4 next line");
    // R5 invalid entry never matches, then valid does
    run(32'h0000_4004, 32'h0000_4004, 1'b1, 1'b0, 2, 1'b0, 4'b0000, "R5 invalid");
    buf_valid = 4'b0101;
    run(32'h0000_4004, 32'h0000_4004, 1'b1, 1'b0, 2, 1'b1, 4'b0010, "R5 valid");
    buf_valid = 4'b0001;

    // R6 busy-bus read
    io_busy_snoop = 1'b1;
    run(32'h8000, 32'h8000, 1'b0, 1'b1, 2, 1'b1, 4'b0100, "R6 io read");
    run(32'h8000, 32'h8000, 1'b1, 1'b1, 2, 1'b0, 4'b0000, "R6 io write");
    run(32'h8000, 32'h8000, 1'b0, 1'b0, 2, 1'b0, 4'b0000, "R6 mem read");
    io_busy_snoop = 1'b0;

    // R7 full write buffer with snoop waiting
    io_wbuf_full = 1'b1; io_mem_snoop = 1'b1;
    run(32'h8000, 32'h8000, 1'b1, 1'b1, 2, 1'b1, 4'b1000, "R7 both");
    io_mem_snoop = 1'b0;
    run(32'h8000, 32'h8000, 1'b1, 1'b1, 2, 1'b0, 4'b0000, "R7 full only");
    io_wbuf_full = 1'b0; io_mem_snoop = 1'b1;
    run(32'h8000, 32'h8000, 1'b1, 1'b1, 2, 1'b0, 4'b0000, "R7 snoop only");
    io_mem_snoop = 1'b0;

    // R11 two causes together
    l2_castout = 1'b1;
    run(32'h0000_1008, 32'h0000_1008, 1'b0, 1'b0, 2, 1'b1, 4'b0011, "R11 two causes");
    l2_castout = 1'b0;

    // R12 address taken at transfer-start only
    run(32'h0000_3000, 32'h0000_1000, 1'b0, 1'b0, 3, 1'b0, 4'b0000, "R12 late addr");

    // R10 pulses across the window (aack at offset 3, final cycle at offset 4)
    run_pulse(3, 2, "R10 mid");
    run_pulse(3, 3, "R10 at aack");
    run_pulse(3, 4, "R10 final cycle");

    repeat (4) step;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule